// File: doc/BRIEF.md
# Credit-Gated Packet Release for One Virtual Channel

This block sits on the transmit side of a packet link and decides whether a pending outbound packet may be handed to the link layer. It keeps a view of the buffer space that the far receiver has advertised for one virtual channel. That view is split into three credit categories: posted, non-posted and completion. The block raises a grant only when the category that the pending packet belongs to has enough credit left. Each grant consumes credit at once, so back-to-back grants never overrun the receiver.

Credit information arrives as already-decoded records. Each record carries a kind (init phase one, init phase two or update), a category and a credit value. After `init_start`, the gate stays closed while the channel runs a two-phase start-up. It opens only when phase-one values have been seen for all three categories and a phase-two record has followed. Pulsing `init_start` again restarts the sequence. This is how a newly enabled channel, or a channel being re-trained, is brought up. Once the channel is active, update records raise the credit limits. An advertised zero during start-up marks that category as unlimited.

Top module: `fc_credit_gate`

## Requirements
- R1: After reset the channel state is IDLE (`fc_state` = 0), and `pkt_grant` stays low whatever the packet inputs are.
- R2: A cycle with `init_start` high moves the state to INIT1 (`fc_state` = 1) on the next edge from any state. It clears all credit state, and no grant is given until the state is ACTIVE again.
- R3: In INIT1, records with `rec_kind` = 0 (phase one) load the limit of category `rec_cat`, where 0 = posted, 1 = non-posted and 2 = completion. The state moves to INIT2 (`fc_state` = 2) on the edge that accepts the last of the three categories still missing, in any order.
- R4: In INIT2, a record with `rec_kind` = 1 (phase two) moves the state to ACTIVE (`fc_state` = 3). A record whose kind does not belong to the current state leaves state and credits unchanged.
- R5: While ACTIVE, `pkt_grant` is high in the same cycle as `pkt_valid` exactly when (limit − consumed) mod 2^CNT_W ≥ `pkt_need` for the category `pkt_cat`. Category 3 is never granted.
- R6: On every edge where `pkt_grant` is high, the consumed count of that category grows by `pkt_need`. The credit available in the next cycle is smaller by that amount.
- R7: A phase-one value of zero makes that category unlimited until the next `init_start`. Any need is granted, and update records for it have no effect.
- R8: An update record (`rec_kind` = 2) in ACTIVE sets the new limit only when (new − old) mod 2^CNT_W lies in 1 … 2^(CNT_W−1)−1. An update that would move the limit backwards is ignored.
- R9: Limits and consumed counts wrap modulo 2^CNT_W, and available credit stays correct across the wrap.
- R10: The three categories are independent. Grants and updates on one category leave the credit available in the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_start | input | 1 | Restart flow-control start-up for this channel |
| rec_valid | input | 1 | Credit record present this cycle |
| rec_kind | input | 2 | 0 = phase one, 1 = phase two, 2 = update |
| rec_cat | input | 2 | 0 = posted, 1 = non-posted, 2 = completion |
| rec_credits | input | CNT_W | Advertised credit limit |
| pkt_valid | input | 1 | A packet is waiting to be released |
| pkt_cat | input | 2 | Category of the waiting packet |
| pkt_need | input | CNT_W | Credits the waiting packet consumes |
| pkt_grant | output | 1 | Packet may be released this cycle |
| fc_state | output | 2 | 0 IDLE, 1 INIT1, 2 INIT2, 3 ACTIVE |

## Verification
The bench aims at the exact credit boundary, where a need equal to the credit left is granted and one more is refused. An off-by-one comparison would either overrun the receiver or stall a packet that fits. It pushes a limit and the consumed count across the 8-bit wrap; a design that compares the raw values instead of their modular difference would refuse grants there. It also sends backward and far-forward updates, and updates to an unlimited category. A design that accepts those would make credit vanish or appear. Finally, it checks that the state does not advance before all three phase-one categories arrive, and that a restart closes the gate at once.

// File: rtl/fc_pkg.sv
// Package: shared encodings for the credit gate.
// Assumes: records are decoded upstream into kind/category/value.
package fc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INIT1  = 2'd1,
        ST_INIT2  = 2'd2,
        ST_ACTIVE = 2'd3
    } fc_state_e;

    typedef enum logic [1:0] {
        RK_PHASE1 = 2'd0,
        RK_PHASE2 = 2'd1,
        RK_UPDATE = 2'd2,
        RK_RSVD   = 2'd3
    } rec_kind_e;

    localparam int NUM_CAT = 3;
endpackage

// File: rtl/fc_init_fsm.sv
// Module: fc_init_fsm
// Tracks the two-phase start-up of one channel: IDLE -> INIT1 on a restart,
// INIT1 -> INIT2 once phase-one values for all categories arrived,
// INIT2 -> ACTIVE on a phase-two record.
// Assumes: rec_* are only meaningful with rec_valid; category 3 is reserved.
module fc_init_fsm
    import fc_pkg::*;
#(
    parameter int NCAT = NUM_CAT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_start,
    input  logic            rec_valid,
    input  logic [1:0]      rec_kind,
    input  logic [1:0]      rec_cat,
    output fc_state_e       state
);
    localparam logic [NCAT-1:0] ALL_SEEN = {NCAT{1'b1}};

    logic [NCAT-1:0] seen_q;
    logic [NCAT-1:0] seen_nx;
    logic            p1_hit;
    logic            p2_hit;

    // Decode which record kinds are relevant to the current state.
    always_comb begin
        p1_hit  = rec_valid && (rec_kind == RK_PHASE1) && (state == ST_INIT1)
                  && (int'(rec_cat) < NCAT);
        p2_hit  = rec_valid && (rec_kind == RK_PHASE2) && (state == ST_INIT2);
        seen_nx = seen_q;
        if (p1_hit) seen_nx[rec_cat] = 1'b1;
    end

    // State and seen-category register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            seen_q <= '0;
        end else if (init_start) begin
            state  <= ST_INIT1;
            seen_q <= '0;
        end else begin
            seen_q <= seen_nx;
            if (state == ST_INIT1 && seen_nx == ALL_SEEN) state <= ST_INIT2;
            else if (p2_hit)                              state <= ST_ACTIVE;
        end
    end

    // R4: ACTIVE is only ever entered from INIT2.
    a_r4_active_from_init2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && $past(state) != ST_ACTIVE && !$past(init_start))
        |-> $past(state) == ST_INIT2);

    // R3: INIT2 is only entered from INIT1.
    a_r3_init2_from_init1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT2 && $past(state) != ST_INIT2) |-> $past(state) == ST_INIT1);
endmodule

// File: rtl/fc_credit_slot.sv
// Module: fc_credit_slot
// Holds the advertised limit and the consumed count of one credit category,
// both modulo 2^CNT_W, and reports the credit left or an unlimited flag.
// Assumes: take_amt never exceeds avail unless unlimited (the grant logic
// guarantees this); clear has priority over every load.
module fc_credit_slot #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ld_init,
    input  logic             ld_upd,
    input  logic [CNT_W-1:0] val,
    input  logic             take,
    input  logic [CNT_W-1:0] take_amt,
    output logic [CNT_W-1:0] avail,
    output logic             unlimited
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] used_q;
    logic [CNT_W-1:0] delta;
    logic             forward;

    // Credit left and direction of a proposed update.
    always_comb begin
        avail   = limit_q - used_q;
        delta   = val - limit_q;
        forward = (delta != '0) && (delta < HALF);
    end

    // Limit and unlimited flag: set at init, raised only forward by updates.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            limit_q   <= '0;
            unlimited <= 1'b0;
        end else if (ld_init) begin
            limit_q   <= val;
            unlimited <= (val == '0);
        end else if (ld_upd && !unlimited && forward) begin
            limit_q   <= val;
        end
    end

    // Consumed count: restarts at init, advances by each granted need.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || ld_init) used_q <= '0;
        else if (take && !unlimited)    used_q <= used_q + take_amt;
    end

    // R6: a grant never takes more than the credit left.
    a_r6_take_within_avail: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (unlimited || take_amt <= avail));

    // R8: a backward or null update leaves the limit alone.
    a_r8_backward_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_upd && !clear && !ld_init && !forward) |=> $stable(limit_q));

    // R7: an unlimited category stays unlimited until cleared or reloaded.
    a_r7_unlimited_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unlimited && !clear && !ld_init) |=> unlimited);
endmodule

// File: rtl/fc_credit_gate.sv
// Module: fc_credit_gate (top)
// Credit gate for one virtual channel: start-up sequencing, one credit slot
// per category, and the same-cycle grant decision for the pending packet.
// Assumes: pkt_* may change every cycle; a granted packet is taken by the
// link layer in that same cycle.
module fc_credit_gate
    import fc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_start,
    input  logic             rec_valid,
    input  logic [1:0]       rec_kind,
    input  logic [1:0]       rec_cat,
    input  logic [CNT_W-1:0] rec_credits,
    input  logic             pkt_valid,
    input  logic [1:0]       pkt_cat,
    input  logic [CNT_W-1:0] pkt_need,
    output logic             pkt_grant,
    output logic [1:0]       fc_state
);
    fc_state_e          state;
    logic [CNT_W-1:0]   avail    [NUM_CAT];
    logic [NUM_CAT-1:0] unlim;
    logic [NUM_CAT-1:0] ok;

    fc_init_fsm #(.NCAT(NUM_CAT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_start (init_start),
        .rec_valid  (rec_valid),
        .rec_kind   (rec_kind),
        .rec_cat    (rec_cat),
        .state      (state)
    );

    for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
        logic ld_init, ld_upd, take;

        // Route records and grants to this category's slot.
        always_comb begin
            ld_init = rec_valid && rec_kind == RK_PHASE1 && state == ST_INIT1
                      && rec_cat == 2'(c);
            ld_upd  = rec_valid && rec_kind == RK_UPDATE && state == ST_ACTIVE
                      && rec_cat == 2'(c);
            take    = pkt_grant && pkt_cat == 2'(c);
            ok[c]   = unlim[c] || (avail[c] >= pkt_need);
        end

        fc_credit_slot #(.CNT_W(CNT_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (init_start),
            .ld_init   (ld_init),
            .ld_upd    (ld_upd),
            .val       (rec_credits),
            .take      (take),
            .take_amt  (pkt_need),
            .avail     (avail[c]),
            .unlimited (unlim[c])
        );
    end

    // Grant decision for the pending packet.
    always_comb begin
        pkt_grant = 1'b0;
        if (pkt_valid && state == ST_ACTIVE && int'(pkt_cat) < NUM_CAT)
            pkt_grant = ok[pkt_cat];
    end

    assign fc_state = state;

    // R2: the cycle after a restart the gate is closed.
    a_r2_closed_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_start) |-> !pkt_grant);

    // R5: reserved category is never granted.
    a_r5_no_rsvd_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cat == 2'd3) |-> !pkt_grant);
endmodule

// File: tb/fc_credit_gate_tb.sv
module fc_credit_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_start = 1'b0;
    logic         rec_valid = 1'b0;
    logic [1:0]   rec_kind = '0;
    logic [1:0]   rec_cat = '0;
    logic [W-1:0] rec_credits = '0;
    logic         pkt_valid = 1'b0;
    logic [1:0]   pkt_cat = '0;
    logic [W-1:0] pkt_need = '0;
    logic         pkt_grant;
    logic [1:0]   fc_state;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fc_credit_gate #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_start(init_start),
        .rec_valid(rec_valid), .rec_kind(rec_kind), .rec_cat(rec_cat),
        .rec_credits(rec_credits), .pkt_valid(pkt_valid), .pkt_cat(pkt_cat),
        .pkt_need(pkt_need), .pkt_grant(pkt_grant), .fc_state(fc_state)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Send one record across one clock edge.
    task automatic send(input int kind, input int cat, input int val);
        @(negedge clk);
        rec_valid = 1'b1; rec_kind = 2'(kind); rec_cat = 2'(cat); rec_credits = W'(val);
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    // Probe the grant without letting it consume.
    task automatic probe(input string req, input int cat, input int need, input int exp);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_cat = 2'(cat); pkt_need = W'(need);
        #1 check(req, int'(pkt_grant), exp);
        pkt_valid = 1'b0;
    endtask

    // Let a packet through for one edge.
    task automatic consume(input string req, input int cat, input int need);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_cat = 2'(cat); pkt_need = W'(need);
        #1 check(req, int'(pkt_grant), 1);
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 state", int'(fc_state), 0);
        probe("R1 grant", 0, 1, 0);
    endtask

    task automatic t_init();
        restart();
        check("R2 state INIT1", int'(fc_state), 1);
        send(2, 0, 50);                       // update in INIT1 ignored
        check("R4 wrong kind", int'(fc_state), 1);
        send(0, 2, 4);
        send(0, 0, 10);
        check("R3 two of three", int'(fc_state), 1);
        send(0, 0, 10);                       // repeat, still waiting
        check("R3 repeat", int'(fc_state), 1);
        send(0, 1, 0);                        // non-posted unlimited
        check("R3 INIT2", int'(fc_state), 2);
        probe("R2 closed in INIT2", 0, 1, 0);
        send(2, 0, 100);                      // update in INIT2 ignored
        send(1, 0, 10);
        check("R4 ACTIVE", int'(fc_state), 3);
    endtask

    task automatic t_grant();
        probe("R5 exact", 0, 10, 1);
        probe("R5 one over", 0, 11, 0);
        consume("R6 take", 0, 6);
        probe("R6 left+1", 0, 5, 0);
        probe("R6 left", 0, 4, 1);
    endtask

    task automatic t_unlimited();
        probe("R7 big need", 1, 200, 1);
        consume("R7 take", 1, 255);
        send(2, 1, 3);
        probe("R7 still unlimited", 1, 255, 1);
    endtask

    task automatic t_update();
        send(2, 0, 8);                        // backwards
        probe("R8 backward ignored", 0, 5, 0);
        send(2, 0, 20);                       // avail 14
        probe("R8 forward", 0, 14, 1);
        probe("R8 forward+1", 0, 15, 0);
        send(2, 0, 220);                      // delta 200: backwards
        probe("R8 far ignored", 0, 15, 0);
    endtask

    task automatic t_wrap();
        send(2, 0, 140);                      // avail 134
        consume("R9 take100", 0, 100);        // used 106
        send(2, 0, 250);                      // avail 144
        consume("R9 take120", 0, 120);        // used 226
        send(2, 0, 350 % 256);                // limit 94, avail 124
        probe("R9 wrap exact", 0, 124, 1);
        probe("R9 wrap over", 0, 125, 0);
    endtask

    task automatic t_indep();
        probe("R10 cpl exact", 2, 4, 1);
        probe("R10 cpl over", 2, 5, 0);
        probe("R5 reserved cat", 3, 0, 0);
    endtask

    task automatic t_restart();
        restart();
        check("R2 restart state", int'(fc_state), 1);
        probe("R2 restart closed", 2, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init();
        t_grant();
        t_unlimited();
        t_update();
        t_wrap();
        t_indep();
        t_restart();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule